// File: doc/BRIEF.md
# Pipelined Radix-8 Significand Divider

This block divides one normalised significand by another for a floating-point divide unit. Both operands are unsigned integers of `FRAC_W+1` bits, and each has its most significant bit set. The block returns a quotient with one integer bit and `FRAC_W+2` fraction bits. The two extra fraction bits are the guard and round positions. It also returns a sticky flag that is set when the division left a non-zero remainder. Exponent handling, special operands, normalisation and rounding are done by neighbouring logic.

The first register stage handles the integer quotient bit with a single compare and subtract, then runs `ITERS-1` radix-8 digit steps. Each middle stage chains `ITERS` digit steps combinationally, and the last stage runs whatever steps remain. A digit step uses restoring selection: it finds the largest multiple of the divisor, from 1 to 7, that does not exceed the remainder shifted left by three. When the fraction width is not a multiple of three, the final step produces only one or two bits.

A request tag travels beside each operation and comes back with its result. The valid/ready handshake stalls the whole pipeline without losing data.

Top module: `mant_div8_pipe`

## Requirements
- R1: With dividend A and divisor B, `out_quot` equals floor(A * 2^(FRAC_W+2) / B), `FRAC_W+3` bits wide. The MSB is the integer bit and the two LSBs are the guard and round bits.
- R2: `out_sticky` is 1 exactly when A * 2^(FRAC_W+2) mod B is non-zero.
- R3: Results leave in acceptance order, and each carries the `in_tag` value given with its request.
- R4: With `out_ready` held high, an operation accepted at a clock edge shows `out_valid` high after NST edges, counting the accepting edge. NST = 1 + ceil((FRAC_W+2)/3) / ITERS, using integer division, which gives 5 for the defaults and 2 for FRAC_W=5. The block accepts one operation per cycle.
- R5: An operation is taken only on an edge where `in_valid` and `in_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_quot`, `out_sticky` and `out_tag` hold their values, and no operation is lost.
- R6: Whenever `out_ready` is high, `in_ready` is high.
- R7: For normalised operands, every valid quotient has at least one of its top two bits set.
- R8: The number of accepted but undelivered operations never exceeds NST.
- R9: While reset is asserted and after its release, `out_valid` is low and `in_ready` is high until the first operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| in_dividend | input | FRAC_W+1 | Dividend significand, MSB set |
| in_divisor | input | FRAC_W+1 | Divisor significand, MSB set |
| in_tag | input | TAG_W | Request identifier |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_quot | output | FRAC_W+3 | Quotient with guard and round bits |
| out_sticky | output | 1 | Final remainder non-zero |
| out_tag | output | TAG_W | Identifier of the returned request |

## Verification
A wrong digit choice in any stage leaves a remainder outside the range 0 to B-1. Every later digit then goes wrong, so the error shows up as a wrong quotient or sticky bit as soon as that operation reaches the output, NST cycles after it was accepted. A fault in the ready chain or the stage registers shows up as a duplicated or dropped tag, or as output that changes during a stall. The bench sees this on the first stalled cycle or at the next in-order tag comparison. An exhaustive sweep over all operand pairs of a 6-bit significand tests every digit value at every step, including the shortened final step.

// File: rtl/mant_div8_pipe.sv
module mant_div8_pipe #(
  parameter int FRAC_W = 23,
  parameter int TAG_W  = 4,
  parameter int ITERS  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [FRAC_W:0]     in_dividend,
  input  logic [FRAC_W:0]     in_divisor,
  input  logic [TAG_W-1:0]    in_tag,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [FRAC_W+2:0]   out_quot,
  output logic                out_sticky,
  output logic [TAG_W-1:0]    out_tag
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int FB    = FRAC_W + 2;
  localparam int QB    = FB + 1;
  localparam int RW    = SIG_W + 3;
  localparam int NIT   = (FB + 2) / 3;
  localparam int LASTD = FB - 3 * (NIT - 1);
  localparam int NST   = 1 + NIT / ITERS;

  function automatic logic [RW+2:0] digit_step(input logic [RW-1:0] r,
                                               input logic [SIG_W-1:0] b,
                                               input int d);
    logic [RW-1:0] sh, rest, trial;
    logic [2:0] dg;
    sh = r << d;
    rest = sh;
    dg = '0;
    for (int m = 1; m < 8; m++) begin
      trial = RW'(m) * {3'b000, b};
      if (m < (1 << d) && sh >= trial) begin
        dg = 3'(m);
        rest = sh - trial;
      end
    end
    return {dg, rest};
  endfunction

  logic [NST:0] adv;
  assign adv[NST] = out_ready;
  assign in_ready = adv[0];

  for (genvar s = 0; s < NST; s++) begin : stg
    localparam int FIRST = (s == 0) ? 0 : s * ITERS - 1;
    localparam int LRAW  = (s == 0) ? ITERS - 2 : s * ITERS + ITERS - 2;
    localparam int LASTI = (LRAW > NIT - 1) ? NIT - 1 : LRAW;

    logic             v;
    logic [RW-1:0]    rem;
    logic [QB-1:0]    quo;
    logic [SIG_W-1:0] dvs;
    logic [TAG_W-1:0] tag;

    logic             pv;
    logic [RW-1:0]    prem, nrem;
    logic [QB-1:0]    pquo, nquo;
    logic [SIG_W-1:0] pdvs;
    logic [TAG_W-1:0] ptag;

    if (s == 0) begin : g_setup
      logic ibit;
      assign ibit = in_dividend >= in_divisor;
      assign pv   = in_valid;
      assign prem = ibit ? RW'(in_dividend) - RW'(in_divisor) : RW'(in_dividend);
      assign pquo = QB'(ibit);
      assign pdvs = in_divisor;
      assign ptag = in_tag;
    end else begin : g_link
      assign pv   = stg[s-1].v;
      assign prem = stg[s-1].rem;
      assign pquo = stg[s-1].quo;
      assign pdvs = stg[s-1].dvs;
      assign ptag = stg[s-1].tag;
    end

    always_comb begin
      logic [RW+2:0] t;
      nrem = prem;
      nquo = pquo;
      t = '0;
      for (int i = FIRST; i <= LASTI; i++) begin
        int d;
        d = (i == NIT - 1) ? LASTD : 3;
        t = digit_step(nrem, pdvs, d);
        nquo = (nquo << d) | QB'(t[RW+2:RW]);
        nrem = t[RW-1:0];
      end
    end

    assign adv[s] = !v || adv[s+1];

    always_ff @(posedge clk) begin
      if (!rst_n) v <= 1'b0;
      else if (adv[s]) v <= pv;
      if (adv[s]) begin
        rem <= nrem;
        quo <= nquo;
        dvs <= pdvs;
        tag <= ptag;
      end
    end
  end

  assign out_valid  = stg[NST-1].v;
  assign out_quot   = stg[NST-1].quo;
  assign out_sticky = |stg[NST-1].rem;
  assign out_tag    = stg[NST-1].tag;
endmodule

module mant_div8_pipe_chk #(
  parameter int FRAC_W = 23,
  parameter int TAG_W  = 4,
  parameter int ITERS  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [FRAC_W+2:0] out_quot,
  input logic              out_sticky,
  input logic [TAG_W-1:0]  out_tag
);
  localparam int NIT = (FRAC_W + 4) / 3;
  localparam int NST = 1 + NIT / ITERS;

  int occ;
  always_ff @(posedge clk) begin
    if (!rst_n) occ <= 0;
    else occ <= occ + int'(in_valid && in_ready) - int'(out_valid && out_ready);
  end

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_quot) && $stable(out_sticky) && $stable(out_tag));

  // R6
  ready_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  // R7
  quot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_quot[FRAC_W+2] || out_quot[FRAC_W+1]));

  // R8
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= NST);

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid && in_ready);
endmodule

bind mant_div8_pipe mant_div8_pipe_chk #(.FRAC_W(FRAC_W), .TAG_W(TAG_W), .ITERS(ITERS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_quot(out_quot),
  .out_sticky(out_sticky), .out_tag(out_tag)
);

// File: tb/mant_div8_pipe_tb.sv
module mant_div8_pipe_tb;
  localparam int FW  = 5;
  localparam int TW  = 4;
  localparam int QB  = FW + 3;
  localparam int NST = 2;
  localparam int NP  = 1024;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [FW:0] in_dividend = 0, in_divisor = 0;
  logic [TW-1:0] in_tag = 0;
  logic in_ready, out_valid, out_sticky;
  logic [QB-1:0] out_quot;
  logic [TW-1:0] out_tag;

  always #4 clk = ~clk;

  mant_div8_pipe #(.FRAC_W(FW), .TAG_W(TW), .ITERS(2)) u_dut (.*);

  int tests = 0, fails = 0;
  bit timeout = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int opa(input int i); return 32 + (i / 32); endfunction
  function automatic int opb(input int i); return 32 + (i % 32); endfunction
  function automatic int expq(input int i); return (opa(i) << (FW + 2)) / opb(i); endfunction
  function automatic int exps(input int i); return int'(((opa(i) << (FW + 2)) % opb(i)) != 0); endfunction

  task automatic check_result(input int i);
    check(out_quot == QB'(expq(i)), "R1 quotient", out_quot, expq(i));
    check(out_sticky == exps(i)[0], "R2 sticky", out_sticky, exps(i));
    check(out_tag == TW'(i), "R3 tag order", out_tag, i % 16);
    check(out_quot[QB-1] || out_quot[QB-2], "R7 range", out_quot, expq(i));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    timeout = 1;
  end

  initial begin
    int lat, sent, rcv;
    bit stalled;
    logic [QB-1:0] sq;
    logic [TW-1:0] st;

    repeat (3) @(posedge clk);
    #1;
    check(!out_valid, "R9 reset out_valid", out_valid, 0);
    check(in_ready, "R9 reset in_ready", in_ready, 1);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check(!out_valid && in_ready, "R9 idle after reset", {out_valid, in_ready}, 1);

    // R4 latency, single operation (pair index 1000)
    in_valid = 1; out_ready = 1;
    in_dividend = 6'(opa(1000)); in_divisor = 6'(opb(1000)); in_tag = TW'(1000);
    @(posedge clk); #1;
    in_valid = 0;
    lat = 1;
    while (!out_valid && lat < 40) begin @(posedge clk); #1; lat++; end
    check(lat == NST, "R4 latency", lat, NST);
    check_result(1000);
    @(negedge clk);

    sent = 0; rcv = 0; stalled = 0; sq = '0; st = '0;
    while (rcv < NP && !timeout) begin
      bit burst;
      @(negedge clk);
      burst = sent < 64;
      out_ready = burst ? 1'b1 : ($urandom % 10 < 7);
      if (!in_valid) begin
        if (sent < NP && (burst || $urandom % 10 < 8)) begin
          in_valid = 1;
          in_dividend = 6'(opa(sent)); in_divisor = 6'(opb(sent)); in_tag = TW'(sent);
        end
      end
      #1;
      if (stalled)
        check(out_valid && out_quot == sq && out_tag == st, "R5 stall hold", out_quot, sq);
      if (out_ready) check(in_ready, "R6 ready pass", in_ready, 1);
      if (burst && rcv > 0) check(in_ready && out_ready, "R4 full rate", in_ready, 1);
      if (out_valid && out_ready) begin
        check_result(rcv);
        rcv++;
      end
      stalled = out_valid && !out_ready;
      sq = out_quot; st = out_tag;
      if (in_valid && in_ready) begin
        sent++;
        @(posedge clk); #1;
        in_valid = 0;
        if (sent < NP && (sent < 64 || $urandom % 10 < 8)) begin
          in_valid = 1;
          in_dividend = 6'(opa(sent)); in_divisor = 6'(opb(sent)); in_tag = TW'(sent);
        end
      end
    end
    if (timeout) check(0, "R5 watchdog expired", rcv, NP);
    check(rcv == NP && sent == NP, "R5 no loss", rcv, NP);
    @(negedge clk);
    check(!out_valid, "R8 drained", out_valid, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule